// File: doc/BRIEF.md
# Free-Running Counter with Software Snapshot

The block keeps a wide counter that advances by one on every clock in which the `tick` input is high, and never stops or reloads. Software does not read the live count. It reads a snapshot held in two half-width registers, low and high, which change only when software asks.

A control register carries two self-clearing command bits. The latch command captures the whole live count into the two snapshot registers in a single clock edge, so the halves always belong to the same count. The clear command sets both snapshot registers to zero. Software may also write either snapshot register directly. The other control bits are plain storage that reads back unchanged.

The register port is a simple single-cycle write port plus a combinational read port, both byte-addressed.

Top module: `tick_snapshot_ctr`

## Requirements
- R1: After reset, reads of the control, low and high registers return zero, and the live count is zero.
- R2: The live count rises by exactly one at each clock edge where `tick` is high, and holds where `tick` is low.
- R3: The count wraps modulo 2^(2*REG_W). A carry out of the low half reaches the high half at the same edge, so a captured value is never torn.
- R4: A write to the control register (offset 0x0) with bit 1 (latch) set copies the count held just before that edge into the snapshot. Count bits [REG_W-1:0] go to the low register and bits [2*REG_W-1:REG_W] go to the high register.
- R5: A write to the control register with bit 0 (clear) set makes both snapshot registers zero.
- R6: When latch and clear are written together, the latch acts first and the clear second, so both snapshot registers end at zero.
- R7: Control bits 0 and 1 always read back as zero after the write that carries them. All other control bits read back exactly as written.
- R8: The low register at offset 0x4 and the high register at offset 0x8 read back what was last written to them. A write to any other offset changes no register, and a read of such an offset returns zero.
- R9: Register writes and commands never disturb the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; the count advances at each edge where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | REG_W | Read data, combinational from `rd_addr` |

## Verification
Two things can happen at the same edge. A latch command can arrive at an edge where `tick` is high, and the snapshot must then hold the count from before that increment. The clear and latch bits can also arrive in one write, and the clear must win. The bench holds `tick` high across a latch write and compares the snapshot with the count it recorded one half-cycle before the edge. It then writes both command bits at once over non-zero snapshot contents and expects zeros. The carry into the high half is exercised on a narrow second instance. That instance is stepped to its top value and then one tick past it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      TSC_NONE = 2'd0,
      TSC_CTL  = 2'd1,
      TSC_LO   = 2'd2,
      TSC_HI   = 2'd3
   } tsc_sel_e;
endpackage

// File: rtl/tsc_count_core.sv
module tsc_count_core #(
   parameter int CNT_W     = 64,
   parameter int SEG_W     = 16,
   parameter bit SEGMENTED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   localparam int NSEG = CNT_W / SEG_W;

   if (CNT_W % SEG_W != 0) begin : g_bad_seg
      $error("CNT_W must be a multiple of SEG_W");
   end

   if (SEGMENTED) begin : g_seg
      logic [NSEG-1:0][SEG_W-1:0] seg_q;
      logic [NSEG:0]              carry;
      assign carry[0] = tick;
      for (genvar g = 0; g < NSEG; g++) begin : g_s
         logic [SEG_W-1:0] nxt;
         assign {carry[g+1], nxt} = {1'b0, seg_q[g]} + (SEG_W+1)'(carry[g]);
         always_ff @(posedge clk) begin
            if (!rst_n) seg_q[g] <= '0;
            else        seg_q[g] <= nxt;
         end
      end
      assign cnt = seg_q;
   end else begin : g_flat
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_q + CNT_W'(tick);
      end
      assign cnt = cnt_q;
   end
endmodule

// File: rtl/tsc_addr_decode.sv
module tsc_addr_decode
   import tsc_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int OFF_CTL = 0,
   parameter int OFF_LO  = 4,
   parameter int OFF_HI  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output tsc_sel_e          sel
);
   always_comb begin
      if (addr == ADDR_W'(OFF_CTL))     sel = TSC_CTL;
      else if (addr == ADDR_W'(OFF_LO)) sel = TSC_LO;
      else if (addr == ADDR_W'(OFF_HI)) sel = TSC_HI;
      else                              sel = TSC_NONE;
   end
endmodule

// File: rtl/tsc_snap_bank.sv
module tsc_snap_bank
   import tsc_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int CLR_BIT = 0,
   parameter int LAT_BIT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  tsc_sel_e           wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   input  tsc_sel_e           rd_sel,
   input  logic [2*REG_W-1:0] cnt,
   output logic [REG_W-1:0]   rd_data,
   output logic [REG_W-1:0]   snap_lo,
   output logic [REG_W-1:0]   snap_hi
);
   localparam logic [REG_W-1:0] CMD_MASK =
      (REG_W'(1) << CLR_BIT) | (REG_W'(1) << LAT_BIT);

   logic [REG_W-1:0] ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         snap_lo <= '0;
         snap_hi <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            TSC_CTL: begin
               ctl_q <= wr_data & ~CMD_MASK;
               if (wr_data[CLR_BIT]) begin
                  snap_lo <= '0;
                  snap_hi <= '0;
               end else if (wr_data[LAT_BIT]) begin
                  snap_lo <= cnt[REG_W-1:0];
                  snap_hi <= cnt[2*REG_W-1:REG_W];
               end
            end
            TSC_LO:   snap_lo <= wr_data;
            TSC_HI:   snap_hi <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      unique case (rd_sel)
         TSC_CTL: rd_data = ctl_q;
         TSC_LO:  rd_data = snap_lo;
         TSC_HI:  rd_data = snap_hi;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tick_snapshot_ctr.sv
module tick_snapshot_ctr
   import tsc_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int SEG_W     = 16,
   parameter bit SEGMENTED = 1'b1,
   parameter int ADDR_W    = 4,
   parameter int OFF_CTL   = 0,
   parameter int OFF_LO    = 4,
   parameter int OFF_HI    = 8,
   parameter int CLR_BIT   = 0,
   parameter int LAT_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data
);
   localparam int CNT_W = 2 * REG_W;

   if (CLR_BIT == LAT_BIT || CLR_BIT >= REG_W || LAT_BIT >= REG_W) begin : g_bad_bits
      $error("command bits must be distinct and inside the register");
   end
   if (OFF_CTL == OFF_LO || OFF_CTL == OFF_HI || OFF_LO == OFF_HI) begin : g_bad_map
      $error("register offsets must be distinct");
   end
   if (OFF_HI >= (1 << ADDR_W) || OFF_LO >= (1 << ADDR_W) || OFF_CTL >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register offset does not fit ADDR_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [REG_W-1:0] snap_lo_q, snap_hi_q;
   tsc_sel_e         wr_sel, rd_sel;

   tsc_count_core #(.CNT_W(CNT_W), .SEG_W(SEG_W), .SEGMENTED(SEGMENTED)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q)
   );

   tsc_addr_decode #(.ADDR_W(ADDR_W), .OFF_CTL(OFF_CTL), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI))
      u_wr_dec (.addr(wr_addr), .sel(wr_sel));
   tsc_addr_decode #(.ADDR_W(ADDR_W), .OFF_CTL(OFF_CTL), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI))
      u_rd_dec (.addr(rd_addr), .sel(rd_sel));

   tsc_snap_bank #(.REG_W(REG_W), .CLR_BIT(CLR_BIT), .LAT_BIT(LAT_BIT)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .cnt(cnt_q), .rd_data(rd_data),
      .snap_lo(snap_lo_q), .snap_hi(snap_hi_q)
   );
endmodule

// File: rtl/tick_snapshot_ctr_chk.sv
module tick_snapshot_ctr_chk #(
   parameter int REG_W   = 32,
   parameter int ADDR_W  = 4,
   parameter int OFF_CTL = 0,
   parameter int OFF_LO  = 4,
   parameter int CLR_BIT = 0,
   parameter int LAT_BIT = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [REG_W-1:0]   wr_data,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [REG_W-1:0]   rd_data,
   input logic [2*REG_W-1:0] cnt,
   input logic [REG_W-1:0]   snap_lo,
   input logic [REG_W-1:0]   snap_hi
);
   localparam int CNT_W = 2 * REG_W;
   logic ctl_wr;
   assign ctl_wr = wr_en && (wr_addr == ADDR_W'(OFF_CTL));

   // R2 / R3 / R9: step by one with wrap, hold otherwise
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_data[LAT_BIT] && !wr_data[CLR_BIT]) |=> {snap_hi, snap_lo} == $past(cnt));
   // covers R6 as well: clear wins whatever the latch bit holds
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_data[CLR_BIT]) |=> (snap_lo == '0 && snap_hi == '0));
   p_cmd_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(OFF_CTL)) |-> (rd_data[CLR_BIT] == 1'b0 && rd_data[LAT_BIT] == 1'b0));
   p_lo_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OFF_LO)) |=> snap_lo == $past(wr_data));
   p_lo_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(OFF_LO)) |-> rd_data == snap_lo);
   p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(snap_lo) && $stable(snap_hi)));
endmodule

bind tick_snapshot_ctr tick_snapshot_ctr_chk #(
   .REG_W(REG_W), .ADDR_W(ADDR_W), .OFF_CTL(OFF_CTL), .OFF_LO(OFF_LO),
   .CLR_BIT(CLR_BIT), .LAT_BIT(LAT_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt_q),
   .snap_lo(snap_lo_q), .snap_hi(snap_hi_q)
);

// File: tb/tick_snapshot_ctr_test.sv
module tick_snapshot_ctr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        s_wr_en = 1'b0;
   logic [3:0]  s_wr_addr = '0;
   logic [3:0]  s_wr_data = '0;
   logic [3:0]  s_rd_addr = '0;
   logic [3:0]  s_rd_data;
   logic [63:0] model_cnt = '0;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tick_snapshot_ctr uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   tick_snapshot_ctr #(.REG_W(4), .SEG_W(4)) uut_small (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(s_wr_en), .wr_addr(s_wr_addr),
      .wr_data(s_wr_data), .rd_addr(s_rd_addr), .rd_data(s_rd_data)
   );

   always @(posedge clk) if (rst_n && tick) model_cnt <= model_cnt + 64'd1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic s_wr(input logic [3:0] a, input logic [3:0] d);
      @(negedge clk); s_wr_en = 1'b1; s_wr_addr = a; s_wr_data = d;
      @(negedge clk); s_wr_en = 1'b0;
   endtask

   task automatic s_rd(input logic [3:0] a, output logic [3:0] d);
      s_rd_addr = a; #1; d = s_rd_data;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic expect_snap(input string req, input logic [63:0] exp);
      logic [31:0] lo, hi;
      rd(4'h4, lo); rd(4'h8, hi);
      chk({hi, lo} == exp, req, {hi, lo}, exp);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(4'h0, v); chk(v == 0, "R1 ctl", v, 0);
      rd(4'h4, v); chk(v == 0, "R1 lo", v, 0);
      rd(4'h8, v); chk(v == 0, "R1 hi", v, 0);
      wr(4'h0, 32'h2);
      expect_snap("R1 count zero", 64'd0);
   endtask

   task automatic t_count;
      run_ticks(37);
      wr(4'h0, 32'h2);
      expect_snap("R2 R4 latch after 37 ticks", 64'd37);
      repeat (5) @(negedge clk);
      wr(4'h0, 32'h2);
      expect_snap("R2 hold without tick", 64'd37);
   endtask

   task automatic t_latch_while_ticking;
      logic [63:0] e;
      @(negedge clk); tick = 1'b1;
      repeat (3) @(negedge clk);
      e = model_cnt;
      wr_en = 1'b1; wr_addr = 4'h0; wr_data = 32'h2;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      expect_snap("R4 latch takes pre-increment count", e);
      wr(4'h0, 32'h2);
      expect_snap("R9 count continues after latch", model_cnt);
   endtask

   task automatic t_direct_and_clear;
      logic [31:0] v;
      wr(4'h4, 32'hDEAD_BEEF); wr(4'h8, 32'h1357_9BDF);
      rd(4'h4, v); chk(v == 32'hDEAD_BEEF, "R8 lo readback", v, 32'hDEAD_BEEF);
      rd(4'h8, v); chk(v == 32'h1357_9BDF, "R8 hi readback", v, 32'h1357_9BDF);
      wr(4'h0, 32'h1);
      expect_snap("R5 clear zeroes snapshot", 64'd0);
      rd(4'h0, v); chk(v == 0, "R7 clear bit self-clears", v, 0);
   endtask

   task automatic t_both;
      logic [31:0] v;
      run_ticks(9);
      wr(4'h4, 32'h1111_2222); wr(4'h8, 32'h3333_4444);
      wr(4'h0, 32'h3);
      expect_snap("R6 latch plus clear ends zero", 64'd0);
      rd(4'h0, v); chk(v == 0, "R7 both bits self-clear", v, 0);
   endtask

   task automatic t_ctl_bits;
      logic [31:0] v;
      wr(4'h4, 32'hCAFE_0001); wr(4'h8, 32'h0000_00F0);
      wr(4'h0, 32'h1234_5670);
      rd(4'h0, v); chk(v == 32'h1234_5670, "R7 plain bits stored", v, 32'h1234_5670);
      expect_snap("R7 no command leaves snapshot", 64'h0000_00F0_CAFE_0001);
      wr(4'h0, 32'hA5A5_0002);
      rd(4'h0, v); chk(v == 32'hA5A5_0000, "R7 latch bit self-clears", v, 32'hA5A5_0000);
      expect_snap("R9 direct writes leave count", model_cnt);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(4'h0, 32'h0000_0F00);
      wr(4'h4, 32'h0000_00AA); wr(4'h8, 32'h0000_00BB);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, v); chk(v == 0, "R8 unmapped reads zero", v, 0);
      rd(4'h0, v); chk(v == 32'h0000_0F00, "R8 unmapped write ignored ctl", v, 32'h0000_0F00);
      expect_snap("R8 unmapped write ignored snap", 64'h0000_00BB_0000_00AA);
   endtask

   task automatic s_expect(input string req, input logic [7:0] exp);
      logic [3:0] lo, hi;
      s_wr(4'h0, 4'h2);
      s_rd(4'h4, lo); s_rd(4'h8, hi);
      chk({hi, lo} == exp, req, {hi, lo}, exp);
   endtask

   task automatic t_small_wrap;
      int n;
      n = (8'hFF - model_cnt[7:0]);
      if (n > 0) run_ticks(n);
      s_expect("R3 narrow count at top", 8'hFF);
      run_ticks(1);
      s_expect("R3 wrap to zero", 8'h00);
      run_ticks(15);
      s_expect("R3 low half full", 8'h0F);
      run_ticks(1);
      s_expect("R3 carry into high half", 8'h10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_latch_while_ticking();
      t_direct_and_clear();
      t_both();
      t_ctl_bits();
      t_unmapped();
      t_small_wrap();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule